// File: doc/BRIEF.md
# Lamp Channel Fault Monitor

This block supervises a single lamp channel of a backlight inverter. A copy sits beside every channel's gate-drive logic. Once per lamp cycle it receives a tick, together with three comparator results: the lamp current is below the lamp-off level, the lamp current is above the overcurrent level, or the high-voltage side is above the overvoltage level. The comparators and peak detectors sit outside the block.

When the channel is enabled, the block first runs a strike phase and waits for a lamp cycle in which current flows. It then moves to the run phase. In the run phase it counts each kind of event over fixed windows of lamp cycles. If any count reaches a programmable threshold, the block declares a fault and removes the drive permission. A policy input chooses what happens next. The channel either restarts the strike after a fixed number of lamp cycles or stays off until it is disabled and enabled again. Sticky per-type status bits record each fault. An output enable drives the shared active-low open-drain fault line.

Top module: `lamp_fault_monitor`

## Requirements
- R1: While `rst` is high, and on the first edge after it, `drive_en`, `fault_status` and `fault_oe` are all zero.
- R2: The clock edge after `chan_en` goes high, `drive_en` rises and the strike phase begins. In the strike phase, a tick with `lamp_low` low moves the channel to the run phase and keeps `drive_en` high.
- R3: If STRIKE_CYCLES (default 1024) consecutive strike-phase ticks all have `lamp_low` high, a strike failure is declared: `fault_status[2]` is set and `drive_en` drops on that same edge.
- R4: In the run phase, ticks with `lamp_low` high are counted. When the count within the current window reaches `thresh`, a lamp-open fault is declared: `fault_status[0]` is set and `drive_en` drops.
- R5: Overcurrent (`lamp_oc`) and overvoltage (`lamp_ov`) events are counted in the same way during the run phase. On reaching `thresh` they set `fault_status[1]` and `fault_status[3]` respectively, and `drive_en` drops.
- R6: A window lasts WIN_CYCLES (default 256) run-phase ticks. All event counts clear at the end of each window, so counts below `thresh` never carry into the next window.
- R7: When `thresh` is zero, no lamp-open, overcurrent or overvoltage fault is declared, whatever the event inputs do.
- R8: Clock cycles with `lamp_tick` low advance no counter or timer, and the event inputs are ignored in those cycles.
- R9: With `retry_en` high, a fault starts a wait of RETRY_CYCLES (default 4096) ticks with `drive_en` low. On the edge of the last tick of that wait, `drive_en` rises again and the strike phase restarts.
- R10: With `retry_en` low, a fault keeps `drive_en` low until `chan_en` goes low and then high again.
- R11: Each status bit stays set until a cycle with `status_clr` high clears it. If a bit is set and cleared on the same edge, the set wins.
- R12: `fault_oe` is high exactly when at least one `fault_status` bit is set. It changes on the same edge as the status bits.
- R13: On the edge after a cycle with `chan_en` low, `drive_en`, `fault_status` and `fault_oe` are all zero. The block also returns to its idle phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable |
| retry_en | input | 1 | 1: retry automatically after a fault; 0: latch off |
| lamp_tick | input | 1 | One-cycle pulse per lamp cycle; qualifies the event inputs |
| lamp_low | input | 1 | Lamp current below the lamp-off level in this lamp cycle |
| lamp_oc | input | 1 | Lamp current above the overcurrent level in this lamp cycle |
| lamp_ov | input | 1 | High-voltage side above the overvoltage level in this lamp cycle |
| thresh | input | 9 | Event count per window that declares a fault; 0 disables these faults |
| status_clr | input | 1 | Clears the sticky status bits |
| drive_en | output | 1 | Permission for the gate drivers to run |
| fault_status | output | 4 | Sticky bits: [0] open, [1] overcurrent, [2] strike failure, [3] overvoltage |
| fault_oe | output | 1 | Pull-down enable for the shared active-low fault line |

## Verification
The lamp-off input is driven in two patterns. A block of 127 events per 256 ticks must never fault, because every window's count stays below the threshold. Events on alternate ticks reach 128 within one window and must fault, which shows that the window clear and the threshold crossing are distinct. A constantly asserted lamp-off input in the strike phase exercises the strike timer. Overcurrent with a clear request on the fault edge shows that a set beats a clear. An overvoltage input held high while ticks arrive only every third cycle shows that untick cycles count for nothing. With the threshold at zero and all events asserted, no fault may appear. Retry and latch-off runs are each followed past the retry delay, which separates the two policies.

// File: rtl/lfm_pkg.sv
package lfm_pkg;
  typedef enum logic [2:0] {
    LFM_IDLE   = 3'd0,
    LFM_STRIKE = 3'd1,
    LFM_RUN    = 3'd2,
    LFM_WAIT   = 3'd3,
    LFM_LATCH  = 3'd4
  } lfm_phase_e;

  localparam int NUM_FLT   = 4;
  localparam int FB_OPEN   = 0;
  localparam int FB_OC     = 1;
  localparam int FB_STRIKE = 2;
  localparam int FB_OV     = 3;
  localparam int NUM_INT   = 3;
endpackage

// File: rtl/lfm_integrator.sv
module lfm_integrator #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          tick,
  input  logic          win_end,
  input  logic          evt,
  input  logic [CW-1:0] thresh,
  output logic          hit
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_inc;

  assign cnt_inc = cnt_q + CW'(1);
  assign hit = run && tick && evt && (thresh != '0) && (cnt_inc == thresh);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (win_end) cnt_q <= '0;
      else if (evt) cnt_q <= cnt_inc;
    end
  end
endmodule

// File: rtl/lfm_seq.sv
module lfm_seq
  import lfm_pkg::*;
#(
  parameter int WIN_CYCLES    = 256,
  parameter int STRIKE_CYCLES = 1024,
  parameter int RETRY_CYCLES  = 4096
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               chan_en,
  input  logic               retry_en,
  input  logic               tick,
  input  logic               lamp_low,
  input  logic [NUM_INT-1:0] int_hit,
  output logic               run,
  output logic               win_end,
  output logic [NUM_FLT-1:0] set_bits,
  output logic               drive_en
);
  localparam int MAXC = (STRIKE_CYCLES > RETRY_CYCLES) ? STRIKE_CYCLES : RETRY_CYCLES;
  localparam int TW   = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam int WW   = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;

  lfm_phase_e phase_q, phase_d;
  logic [TW-1:0] tcnt_q, tcnt_d;
  logic [WW-1:0] wcnt_q, wcnt_d;
  logic strike_fail, any_fault;

  assign run         = (phase_q == LFM_RUN);
  assign win_end     = (wcnt_q == WW'(WIN_CYCLES - 1));
  assign strike_fail = (phase_q == LFM_STRIKE) && tick && lamp_low &&
                       (tcnt_q == TW'(STRIKE_CYCLES - 1));
  assign any_fault   = strike_fail || (|int_hit);

  always_comb begin
    set_bits            = '0;
    set_bits[FB_OPEN]   = int_hit[0];
    set_bits[FB_OC]     = int_hit[1];
    set_bits[FB_OV]     = int_hit[2];
    set_bits[FB_STRIKE] = strike_fail;
  end

  always_comb begin
    phase_d = phase_q;
    tcnt_d  = tcnt_q;
    wcnt_d  = wcnt_q;
    case (phase_q)
      LFM_IDLE: begin
        phase_d = LFM_STRIKE;
        tcnt_d  = '0;
      end
      LFM_STRIKE: if (tick) begin
        if (!lamp_low) begin
          phase_d = LFM_RUN;
          tcnt_d  = '0;
        end else begin
          tcnt_d = tcnt_q + TW'(1);
        end
      end
      LFM_RUN: if (tick) wcnt_d = win_end ? '0 : wcnt_q + WW'(1);
      LFM_WAIT: if (tick) begin
        if (tcnt_q == TW'(RETRY_CYCLES - 1)) begin
          phase_d = LFM_STRIKE;
          tcnt_d  = '0;
        end else begin
          tcnt_d = tcnt_q + TW'(1);
        end
      end
      default: phase_d = LFM_LATCH;
    endcase
    if (any_fault) begin
      phase_d = retry_en ? LFM_WAIT : LFM_LATCH;
      tcnt_d  = '0;
    end
    if (phase_d != LFM_RUN) wcnt_d = '0;
    if (!chan_en) begin
      phase_d = LFM_IDLE;
      tcnt_d  = '0;
      wcnt_d  = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= LFM_IDLE;
      tcnt_q   <= '0;
      wcnt_q   <= '0;
      drive_en <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      tcnt_q   <= tcnt_d;
      wcnt_q   <= wcnt_d;
      drive_en <= (phase_d == LFM_STRIKE) || (phase_d == LFM_RUN);
    end
  end
endmodule

// File: rtl/lfm_status.sv
module lfm_status
  import lfm_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               chan_en,
  input  logic               clr,
  input  logic [NUM_FLT-1:0] set_bits,
  output logic [NUM_FLT-1:0] status,
  output logic               fault_oe
);
  logic [NUM_FLT-1:0] status_d;

  assign status_d = chan_en ? ((status & {NUM_FLT{~clr}}) | set_bits) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      status   <= '0;
      fault_oe <= 1'b0;
    end else begin
      status   <= status_d;
      fault_oe <= |status_d;
    end
  end
endmodule

// File: rtl/lamp_fault_monitor.sv
module lamp_fault_monitor
  import lfm_pkg::*;
#(
  parameter int WIN_CYCLES    = 256,
  parameter int STRIKE_CYCLES = 1024,
  parameter int RETRY_CYCLES  = 4096,
  localparam int CW = $clog2(WIN_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chan_en,
  input  logic          retry_en,
  input  logic          lamp_tick,
  input  logic          lamp_low,
  input  logic          lamp_oc,
  input  logic          lamp_ov,
  input  logic [CW-1:0] thresh,
  input  logic          status_clr,
  output logic          drive_en,
  output logic [3:0]    fault_status,
  output logic          fault_oe
);
  logic [NUM_INT-1:0] evt_vec;
  logic [NUM_INT-1:0] int_hit;
  logic               run, win_end;
  logic [NUM_FLT-1:0] set_bits;

  assign evt_vec = {lamp_ov, lamp_oc, lamp_low};

  for (genvar gi = 0; gi < NUM_INT; gi++) begin : g_int
    lfm_integrator #(.CW(CW)) u_int (
      .clk     (clk),
      .rst     (rst),
      .run     (run),
      .tick    (lamp_tick),
      .win_end (win_end),
      .evt     (evt_vec[gi]),
      .thresh  (thresh),
      .hit     (int_hit[gi])
    );
  end

  lfm_seq #(
    .WIN_CYCLES    (WIN_CYCLES),
    .STRIKE_CYCLES (STRIKE_CYCLES),
    .RETRY_CYCLES  (RETRY_CYCLES)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .chan_en  (chan_en),
    .retry_en (retry_en),
    .tick     (lamp_tick),
    .lamp_low (lamp_low),
    .int_hit  (int_hit),
    .run      (run),
    .win_end  (win_end),
    .set_bits (set_bits),
    .drive_en (drive_en)
  );

  lfm_status u_stat (
    .clk      (clk),
    .rst      (rst),
    .chan_en  (chan_en),
    .clr      (status_clr),
    .set_bits (set_bits),
    .status   (fault_status),
    .fault_oe (fault_oe)
  );
endmodule

// File: rtl/lfm_checker.sv
module lfm_checker (
  input logic       clk,
  input logic       rst,
  input logic       chan_en,
  input logic       status_clr,
  input logic       drive_en,
  input logic [3:0] fault_status,
  input logic       fault_oe
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!drive_en && fault_status == 4'b0 && !fault_oe)); // R1

  AST_NEW_FAULT_STOPS_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (|(fault_status & ~$past(fault_status))) |-> !drive_en); // R4

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
    (chan_en && !status_clr) |=> ((fault_status & $past(fault_status)) == $past(fault_status))); // R11

  AST_OE_TRACKS_STATUS: assert property (@(posedge clk) disable iff (rst)
    fault_oe == (fault_status != 4'b0)); // R12

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !chan_en |=> (!drive_en && fault_status == 4'b0 && !fault_oe)); // R13
endmodule

bind lamp_fault_monitor lfm_checker u_lfm_checker (
  .clk          (clk),
  .rst          (rst),
  .chan_en      (chan_en),
  .status_clr   (status_clr),
  .drive_en     (drive_en),
  .fault_status (fault_status),
  .fault_oe     (fault_oe)
);

// File: tb/lamp_fault_monitor_bench.sv
module lamp_fault_monitor_bench;
  localparam int WIN = 256;
  localparam int STK = 1024;
  localparam int RTY = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chan_en = 0, retry_en = 0, lamp_tick = 0, lamp_low = 0, lamp_oc = 0, lamp_ov = 0;
  logic [8:0] thresh = 9'd128;
  logic status_clr = 0;
  logic drive_en, fault_oe;
  logic [3:0] fault_status;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  lamp_fault_monitor u_lamp_fault_monitor (
    .clk(clk), .rst(rst), .chan_en(chan_en), .retry_en(retry_en),
    .lamp_tick(lamp_tick), .lamp_low(lamp_low), .lamp_oc(lamp_oc), .lamp_ov(lamp_ov),
    .thresh(thresh), .status_clr(status_clr),
    .drive_en(drive_en), .fault_status(fault_status), .fault_oe(fault_oe)
  );

  // Behavioural reference: 0 idle, 1 strike, 2 run, 3 wait, 4 latched
  int m_ph = 0, m_t = 0, m_w = 0;
  int m_cnt[3] = '{0, 0, 0};
  int m_stat = 0;
  int m_drv = 0, m_oe = 0;
  bit m_valid = 0;

  always @(posedge clk) begin
    int ev[3];
    int nph, nt, nw, setb, hits;
    int ncnt[3];
    m_valid = 1;
    if (rst) begin
      m_ph = 0; m_t = 0; m_w = 0; m_cnt = '{0, 0, 0};
      m_stat = 0; m_drv = 0; m_oe = 0;
    end else begin
      ev[0] = lamp_low; ev[1] = lamp_oc; ev[2] = lamp_ov;
      hits = 0;
      for (int i = 0; i < 3; i++) begin
        if (m_ph == 2 && lamp_tick && ev[i] == 1 && thresh != 0 && m_cnt[i] + 1 == int'(thresh))
          hits |= (1 << i);
        if (m_ph != 2) ncnt[i] = 0;
        else if (lamp_tick) ncnt[i] = (m_w == WIN - 1) ? 0 : m_cnt[i] + ev[i];
        else ncnt[i] = m_cnt[i];
      end
      setb = (hits & 1) | (hits & 2) | ((hits & 4) << 1);
      nph = m_ph; nt = m_t; nw = m_w;
      if (m_ph == 0) begin nph = 1; nt = 0; end
      else if (m_ph == 1 && lamp_tick) begin
        if (!lamp_low) begin nph = 2; nt = 0; end
        else if (m_t == STK - 1) setb |= 4;
        else nt = m_t + 1;
      end else if (m_ph == 2 && lamp_tick) nw = (m_w == WIN - 1) ? 0 : m_w + 1;
      else if (m_ph == 3 && lamp_tick) begin
        if (m_t == RTY - 1) begin nph = 1; nt = 0; end
        else nt = m_t + 1;
      end
      if (setb != 0) begin nph = retry_en ? 3 : 4; nt = 0; end
      if (nph != 2) nw = 0;
      if (!chan_en) begin nph = 0; nt = 0; nw = 0; end
      m_stat = chan_en ? ((status_clr ? 0 : m_stat) | setb) : 0;
      m_oe = (m_stat != 0);
      m_drv = (nph == 1 || nph == 2);
      m_ph = nph; m_t = nt; m_w = nw; m_cnt = ncnt;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (m_valid && !finished) begin
    chk("R2 R3 R9 R10 R13 drive_en vs model", int'(drive_en), m_drv);
    chk("R4 R5 R6 R7 R8 R11 fault_status vs model", int'(fault_status), m_stat);
    chk("R12 fault_oe vs model", int'(fault_oe), m_oe);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired, all requirements unconfirmed actual=running expected=done");
    summary();
  end

  initial begin
    cyc(3);
    chk("R1 drive_en in reset", int'(drive_en), 0);
    chk("R1 fault_status in reset", int'(fault_status), 0);
    chk("R1 fault_oe in reset", int'(fault_oe), 0);
    rst = 0;
    cyc(2);

    // Strike failure with latch-off
    retry_en = 0; lamp_tick = 1; lamp_low = 1; chan_en = 1;
    cyc(1);
    chk("R2 drive_en after enable", int'(drive_en), 1);
    cyc(1100);
    chk("R3 strike failure status", int'(fault_status), 4'b0100);
    chk("R3 drive off after strike failure", int'(drive_en), 0);
    cyc(4200);
    chk("R10 latched off past retry time", int'(drive_en), 0);
    status_clr = 1; cyc(1); status_clr = 0; cyc(1);
    chk("R11 status cleared by request", int'(fault_status), 0);
    chk("R12 fault_oe released", int'(fault_oe), 0);

    // Re-enable, strike succeeds, windowed open counting
    chan_en = 0; lamp_low = 0; cyc(2);
    chk("R13 drive off while disabled", int'(drive_en), 0);
    chan_en = 1; cyc(2);
    chk("R2 run phase keeps drive", int'(drive_en), 1);
    for (int i = 0; i < 3 * WIN; i++) begin
      lamp_low = ((i % WIN) < 127); cyc(1);
    end
    lamp_low = 0; cyc(1);
    chk("R6 127 per window never faults", int'(fault_status), 0);
    for (int i = 0; i < WIN; i++) begin
      lamp_low = (i % 2 == 0); cyc(1);
    end
    lamp_low = 0; cyc(1);
    chk("R4 open fault at threshold", int'(fault_status), 4'b0001);
    chk("R4 drive off after open fault", int'(drive_en), 0);

    // Overcurrent with retry; set wins over clear on fault edge
    chan_en = 0; cyc(1);
    retry_en = 1; thresh = 9'd4; lamp_oc = 1; chan_en = 1;
    cyc(5);
    status_clr = 1; cyc(1); status_clr = 0;
    chk("R11 set wins over clear", int'(fault_status), 4'b0010);
    chk("R5 overcurrent drive off", int'(drive_en), 0);
    lamp_oc = 0;
    cyc(RTY - 3);
    chk("R9 still waiting before retry ends", int'(drive_en), 0);
    cyc(3);
    chk("R9 drive back after retry", int'(drive_en), 1);

    // Overvoltage with sparse ticks
    chan_en = 0; cyc(1);
    retry_en = 0; thresh = 9'd3; lamp_ov = 1; chan_en = 1;
    for (int i = 0; i < 12; i++) begin
      lamp_tick = (i % 3 == 0); cyc(1);
    end
    chk("R8 untick cycles not counted", int'(fault_status), 0);
    chk("R8 drive still on", int'(drive_en), 1);
    for (int i = 12; i < 15; i++) begin
      lamp_tick = (i % 3 == 0); cyc(1);
    end
    chk("R5 overvoltage fault", int'(fault_status), 4'b1000);
    chk("R12 fault_oe with fault", int'(fault_oe), 1);
    lamp_tick = 1; lamp_ov = 0;
    chan_en = 0; cyc(1);
    chk("R13 status cleared when disabled", int'(fault_status), 0);
    chk("R13 fault_oe cleared when disabled", int'(fault_oe), 0);

    // Threshold zero disables integrated faults
    thresh = 9'd0; chan_en = 1; cyc(2);
    lamp_oc = 1; lamp_ov = 1; lamp_low = 1;
    cyc(600);
    chk("R7 no fault with zero threshold", int'(fault_status), 0);
    chk("R7 drive stays on", int'(drive_en), 1);
    lamp_oc = 0; lamp_ov = 0; lamp_low = 0;
    cyc(2);
    summary();
  end
endmodule